// File: doc/BRIEF.md
# Conversion-Request Priority Arbiter

This block decides which of sixteen conversion slots is handed next to one shared analog converter. Every slot carries a trigger code, an input channel and an acquisition length. Trigger pulses on the external trigger lines, or completion events of the first two interrupt flags, mark slots as pending. The arbiter then grants one pending slot at a time. It drives the slot's channel and acquisition length together with a one-cycle start strobe, waits for the converter's done input, and reports the slot number as the result index.

The lowest-numbered slots, up to a programmable cutoff, form a fixed-priority group. The remaining slots share a round-robin wheel whose pointer remembers the last wheel slot served. A high-priority conversion pauses the wheel without moving its pointer. Up to four interrupt flags can each be tied to the completion of one slot. Flags 0 and 1 also serve as trigger sources, which allows free-running and ping-pong sequences. In burst mode, the wheel slots stop answering their own triggers, and one burst trigger queues a set number of consecutive wheel slots.

Top module: `adc_soc_arbiter`

## Requirements
- R1: A slot whose trigger code fires becomes pending. Code 0 means never, 1 means a set event of interrupt flag 0, 2 means a set event of interrupt flag 1, and 3+j means external trigger line j. Codes at or above 3+NUM_TRIG never fire.
- R2: A trigger for a slot that is already pending and not being granted in that cycle does not add a second request. It sets that slot's sticky overflow bit, which stays set until the slot's overflow-clear input is pulsed.
- R3: At most one conversion is in flight. `conv_start` is never asserted while `conv_busy` is high, and a new grant can come only after the current conversion's `conv_done`.
- R4: A grant produces a one-cycle `conv_start` in the cycle after the pending slot is chosen. `conv_chan` and `conv_acq` then carry that slot's channel and acquisition fields, and `conv_busy` rises with the strobe.
- R5: `conv_done` while busy produces a one-cycle `result_valid` in the next cycle, with `result_idx` equal to the slot that was converted. `conv_done` while idle is ignored.
- R6: The wheel search starts at the slot after `rr_ptr`, wraps modulo 16 and skips high-priority slots. `rr_ptr` takes the number of each granted wheel slot. Reset sets `rr_ptr` to 15, so slot 0 is searched first.
- R7: Slots numbered below `hp_cutoff` are high priority. A pending high-priority slot is granted before any wheel slot, and the lowest-numbered one goes first. Its grant leaves `rr_ptr` unchanged.
- R8: Interrupt flag i is set when slot `int_sel[i]` completes while `int_en[i]` is high. It is cleared by `int_clr[i]`, and a set in the same cycle wins over the clear.
- R9: A set event of flag 0 or flag 1 triggers, in the same cycle as `result_valid` rises, every slot whose code is 1 or 2 respectively. This gives continuous and ping-pong sequences.
- R10: With `burst_en` high, wheel slots ignore their own trigger codes. A firing of `burst_tsel` marks `burst_cnt`+1 consecutive wheel slots after `rr_ptr` pending. High-priority slots keep their own triggers.
- R11: Slots that share one trigger are converted one after another in wheel order from a single pulse. Two slots with the same channel each produce their own conversion and their own result index.
- R12: Reset clears all pending, overflow and interrupt state and leaves the outputs idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | NUM_TRIG | External trigger pulses |
| slot_tsel | input | NUM_SLOTS*TSEL_W | Trigger code per slot |
| slot_chan | input | NUM_SLOTS*CH_W | Channel per slot |
| slot_acq | input | NUM_SLOTS*ACQ_W | Acquisition length per slot |
| hp_cutoff | input | SLOT_W+1 | Number of high-priority slots (0..16) |
| burst_en | input | 1 | Burst mode enable |
| burst_tsel | input | TSEL_W | Trigger code of the burst |
| burst_cnt | input | SLOT_W | Burst length minus one |
| int_sel | input | NUM_INT*SLOT_W | Slot tied to each interrupt flag |
| int_en | input | NUM_INT | Interrupt flag enables |
| int_clr | input | NUM_INT | Interrupt flag clear pulses |
| ovf_clr | input | NUM_SLOTS | Overflow clear pulses |
| conv_done | input | 1 | Converter finished |
| conv_start | output | 1 | Start strobe to the converter |
| conv_chan | output | CH_W | Channel of the granted slot |
| conv_acq | output | ACQ_W | Acquisition length of the granted slot |
| conv_busy | output | 1 | Conversion in flight |
| result_valid | output | 1 | Result index valid pulse |
| result_idx | output | SLOT_W | Slot whose result is ready |
| int_flag | output | NUM_INT | Sticky interrupt flags |
| ovf_flag | output | NUM_SLOTS | Sticky trigger overflow bits |
| rr_ptr | output | SLOT_W | Last wheel slot granted |

## Verification
Four slots on one trigger, two of them with the same channel, show whether one pulse yields a full ordered sequence with separate results. A wheel request combined with high-priority requests that arrive mid-conversion separates the fixed-priority ordering from the wheel ordering, and shows whether the pointer holds still. A second trigger on a slot still queued distinguishes a fresh request from an overflow. A ping-pong loop through flags 0 and 1, and a burst that must ignore a wheel slot's own trigger, test the feedback and burst paths. A behavioural model compares every output in every cycle.

// File: rtl/adc_arb_pkg.sv
// Shared types for the conversion-request arbiter.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package adc_arb_pkg;

    // Converter ownership state.
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;

endpackage

// File: rtl/adc_trig_latch.sv
// Turns trigger events into per-slot pending requests and sticky overflow bits.
// It also expands a burst trigger into a run of consecutive wheel slots.
// Assumes: NUM_SLOTS is a power of two, so pointer arithmetic wraps naturally.
// Code 0 never fires, codes 1 and 2 are interrupt flag set events, and 3+j is trig_in[j].
module adc_trig_latch #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_TRIG  = 8,
    parameter int TSEL_W    = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int CUT_W    = SLOT_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_TRIG-1:0]         trig_in,
    input  logic [1:0]                  int_evt,
    input  logic [NUM_SLOTS*TSEL_W-1:0] slot_tsel,
    input  logic                        burst_en,
    input  logic [TSEL_W-1:0]           burst_tsel,
    input  logic [SLOT_W-1:0]           burst_cnt,
    input  logic [CUT_W-1:0]            hp_cutoff,
    input  logic [SLOT_W-1:0]           rr_ptr,
    input  logic [NUM_SLOTS-1:0]        grant_mask,
    input  logic [NUM_SLOTS-1:0]        ovf_clr,
    output logic [NUM_SLOTS-1:0]        pend,
    output logic [NUM_SLOTS-1:0]        ovf
);

    logic [NUM_SLOTS-1:0] burst_mark;
    logic [NUM_SLOTS-1:0] hit;
    logic [SLOT_W-1:0]    walk_idx;
    logic [SLOT_W:0]      burst_taken;
    logic                 burst_go;

    // Decode one trigger code against the current event lines.
    function automatic logic src_fire(input logic [TSEL_W-1:0] code,
                                      input logic [NUM_TRIG-1:0] ext,
                                      input logic [1:0] ie);
        logic f;
        f = ((code == TSEL_W'(1)) & ie[0]) | ((code == TSEL_W'(2)) & ie[1]);
        for (int j = 0; j < NUM_TRIG; j++) begin
            if (code == TSEL_W'(j + 3)) f = f | ext[j];
        end
        return f;
    endfunction

    // Burst expansion: walk the wheel after the pointer and mark the first burst_cnt+1 wheel slots.
    always_comb begin
        burst_mark  = '0;
        burst_taken = '0;
        walk_idx    = '0;
        burst_go    = burst_en & src_fire(burst_tsel, trig_in, int_evt);
        if (burst_go) begin
            for (int k = 1; k <= NUM_SLOTS; k++) begin
                walk_idx = rr_ptr + SLOT_W'(k);
                if (({1'b0, walk_idx} >= hp_cutoff) && (burst_taken <= {1'b0, burst_cnt})) begin
                    burst_mark[walk_idx] = 1'b1;
                    burst_taken          = burst_taken + 1'b1;
                end
            end
        end
    end

    // Per-slot request: its own code, or the burst mark for wheel slots while bursting.
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if ((CUT_W'(s) < hp_cutoff) || !burst_en)
                hit[s] = src_fire(slot_tsel[s*TSEL_W +: TSEL_W], trig_in, int_evt);
            else
                hit[s] = burst_mark[s];
        end
    end

    // Pending and overflow state; a grant retires a request before a new trigger re-arms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            ovf  <= '0;
        end else begin
            pend <= (pend & ~grant_mask) | hit;
            ovf  <= (ovf & ~ovf_clr) | (hit & pend & ~grant_mask);
        end
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
        // R1: a decoded trigger always leaves the slot pending.
        a_r1_hit_pends: assert property (@(posedge clk) disable iff (!rst_n)
            hit[s] |=> pend[s]);
        // R2: an overflow bit only rises for a slot that was already queued.
        a_r2_ovf_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf[s]) |-> $past(pend[s]));
    end

endmodule

// File: rtl/adc_prio_pick.sv
// Combinational choice of the next slot from the pending set.
// Slots below the cutoff win by lowest number; otherwise the wheel is searched from the slot after the pointer.
// Assumes: NUM_SLOTS is a power of two.
module adc_prio_pick #(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int CUT_W    = SLOT_W + 1
) (
    input  logic [NUM_SLOTS-1:0] pend,
    input  logic [CUT_W-1:0]     hp_cutoff,
    input  logic [SLOT_W-1:0]    rr_ptr,
    output logic                 pick_vld,
    output logic                 pick_hp,
    output logic [SLOT_W-1:0]    pick_idx
);

    logic              hp_found;
    logic              rr_found;
    logic [SLOT_W-1:0] hp_idx;
    logic [SLOT_W-1:0] rr_idx;
    logic [SLOT_W-1:0] probe;

    // Fixed-priority scan: the lowest pending high-priority slot.
    always_comb begin
        hp_found = 1'b0;
        hp_idx   = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (!hp_found && (CUT_W'(s) < hp_cutoff) && pend[s]) begin
                hp_found = 1'b1;
                hp_idx   = SLOT_W'(s);
            end
        end
    end

    // Wheel scan: the first pending wheel slot after the pointer, wrapping around.
    always_comb begin
        rr_found = 1'b0;
        rr_idx   = '0;
        probe    = '0;
        for (int k = 1; k <= NUM_SLOTS; k++) begin
            probe = rr_ptr + SLOT_W'(k);
            if (!rr_found && ({1'b0, probe} >= hp_cutoff) && pend[probe]) begin
                rr_found = 1'b1;
                rr_idx   = probe;
            end
        end
    end

    // Merge: the high-priority group overrides the wheel.
    always_comb begin
        pick_vld = hp_found | rr_found;
        pick_hp  = hp_found;
        pick_idx = hp_found ? hp_idx : rr_idx;
    end

endmodule

// File: rtl/adc_int_flags.sv
// Sticky interrupt flags, each tied to the completion of one chosen slot.
// The set pulses are also exported so they can act as trigger sources.
// Assumes: done_evt is a single-cycle completion event qualified by the caller.
module adc_int_flags #(
    parameter int NUM_INT = 4,
    parameter int SLOT_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      done_evt,
    input  logic [SLOT_W-1:0]         done_slot,
    input  logic [NUM_INT*SLOT_W-1:0] int_sel,
    input  logic [NUM_INT-1:0]        int_en,
    input  logic [NUM_INT-1:0]        int_clr,
    output logic [NUM_INT-1:0]        int_flag,
    output logic [NUM_INT-1:0]        int_set
);

    // Completion matching for every flag.
    always_comb begin
        for (int i = 0; i < NUM_INT; i++) begin
            int_set[i] = done_evt & int_en[i] & (int_sel[i*SLOT_W +: SLOT_W] == done_slot);
        end
    end

    // Flag storage: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) int_flag <= '0;
        else        int_flag <= int_set | (int_flag & ~int_clr);
    end

    for (genvar i = 0; i < NUM_INT; i++) begin : g_int_chk
        // R8: a matching completion raises the flag.
        a_r8_set_on_done: assert property (@(posedge clk) disable iff (!rst_n)
            int_set[i] |=> int_flag[i]);
        // R8: a clear without a simultaneous set drops the flag.
        a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (int_clr[i] && !int_set[i]) |=> !int_flag[i]);
    end

endmodule

// File: rtl/adc_soc_arbiter.sv
// Conversion-request arbiter for one shared converter.
// Latches slot triggers, picks one slot (fixed priority below the cutoff, wheel above),
// issues the slot's channel with a start strobe, waits for done and reports the slot index.
// Assumes: NUM_SLOTS is a power of two; NUM_INT >= 2; conv_done is a single-cycle pulse.
module adc_soc_arbiter #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_TRIG  = 8,
    parameter int TSEL_W    = 4,
    parameter int CH_W      = 5,
    parameter int ACQ_W     = 9,
    parameter int NUM_INT   = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int CUT_W    = SLOT_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_TRIG-1:0]         trig_in,
    input  logic [NUM_SLOTS*TSEL_W-1:0] slot_tsel,
    input  logic [NUM_SLOTS*CH_W-1:0]   slot_chan,
    input  logic [NUM_SLOTS*ACQ_W-1:0]  slot_acq,
    input  logic [CUT_W-1:0]            hp_cutoff,
    input  logic                        burst_en,
    input  logic [TSEL_W-1:0]           burst_tsel,
    input  logic [SLOT_W-1:0]           burst_cnt,
    input  logic [NUM_INT*SLOT_W-1:0]   int_sel,
    input  logic [NUM_INT-1:0]          int_en,
    input  logic [NUM_INT-1:0]          int_clr,
    input  logic [NUM_SLOTS-1:0]        ovf_clr,
    input  logic                        conv_done,
    output logic                        conv_start,
    output logic [CH_W-1:0]             conv_chan,
    output logic [ACQ_W-1:0]            conv_acq,
    output logic                        conv_busy,
    output logic                        result_valid,
    output logic [SLOT_W-1:0]           result_idx,
    output logic [NUM_INT-1:0]          int_flag,
    output logic [NUM_SLOTS-1:0]        ovf_flag,
    output logic [SLOT_W-1:0]           rr_ptr
);

    import adc_arb_pkg::*;

    arb_state_e           state;
    logic [SLOT_W-1:0]    cur_slot;
    logic [NUM_SLOTS-1:0] pend;
    logic [NUM_SLOTS-1:0] grant_mask;
    logic [NUM_INT-1:0]   int_set;
    logic                 pick_vld;
    logic                 pick_hp;
    logic [SLOT_W-1:0]    pick_idx;
    logic                 grant_go;
    logic                 done_evt;

    adc_trig_latch #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_TRIG  (NUM_TRIG),
        .TSEL_W    (TSEL_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (trig_in),
        .int_evt    (int_set[1:0]),
        .slot_tsel  (slot_tsel),
        .burst_en   (burst_en),
        .burst_tsel (burst_tsel),
        .burst_cnt  (burst_cnt),
        .hp_cutoff  (hp_cutoff),
        .rr_ptr     (rr_ptr),
        .grant_mask (grant_mask),
        .ovf_clr    (ovf_clr),
        .pend       (pend),
        .ovf        (ovf_flag)
    );

    adc_prio_pick #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_pick (
        .pend      (pend),
        .hp_cutoff (hp_cutoff),
        .rr_ptr    (rr_ptr),
        .pick_vld  (pick_vld),
        .pick_hp   (pick_hp),
        .pick_idx  (pick_idx)
    );

    adc_int_flags #(
        .NUM_INT (NUM_INT),
        .SLOT_W  (SLOT_W)
    ) u_int (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_evt  (done_evt),
        .done_slot (cur_slot),
        .int_sel   (int_sel),
        .int_en    (int_en),
        .int_clr   (int_clr),
        .int_flag  (int_flag),
        .int_set   (int_set)
    );

    // Grant and completion qualifiers for the current state.
    always_comb begin
        grant_go   = (state == ARB_IDLE) && pick_vld;
        done_evt   = (state == ARB_BUSY) && conv_done;
        grant_mask = '0;
        if (grant_go) grant_mask[pick_idx] = 1'b1;
        conv_busy  = (state == ARB_BUSY);
    end

    // Converter ownership, output registers and wheel pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ARB_IDLE;
            cur_slot     <= '0;
            conv_start   <= 1'b0;
            conv_chan    <= '0;
            conv_acq     <= '0;
            result_valid <= 1'b0;
            result_idx   <= '0;
            rr_ptr       <= '1;
        end else begin
            conv_start   <= grant_go;
            result_valid <= done_evt;
            if (grant_go) begin
                state     <= ARB_BUSY;
                cur_slot  <= pick_idx;
                conv_chan <= slot_chan[pick_idx*CH_W +: CH_W];
                conv_acq  <= slot_acq[pick_idx*ACQ_W +: ACQ_W];
                if (!pick_hp) rr_ptr <= pick_idx;
            end
            if (done_evt) begin
                state      <= ARB_IDLE;
                result_idx <= cur_slot;
            end
        end
    end

    // R3: no new start while a conversion is still waiting for done.
    a_r3_one_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && !conv_done) |=> !conv_start);
    // R4: the strobe is always accompanied by the busy indication.
    a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_busy);
    // R5: done while busy yields a result pulse and frees the converter.
    a_r5_result_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && conv_done) |=> (result_valid && !conv_busy));
    // R5: done while idle produces nothing.
    a_r5_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_busy && conv_done) |=> !result_valid);
    // R7: a high-priority grant leaves the wheel pointer where it was.
    a_r7_hp_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_go && pick_hp) |=> $stable(rr_ptr));
    // R7: while a high-priority slot is pending, no wheel slot is granted.
    a_r7_hp_first: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_go && ((pend & ((NUM_SLOTS'(1) << hp_cutoff) - NUM_SLOTS'(1))) != '0)) |-> pick_hp);

endmodule

// File: tb/adc_soc_arbiter_tb.sv
// Bench for the conversion-request arbiter: a behavioural model compared every cycle,
// plus directed ordering checks.
module adc_soc_arbiter_tb;

    localparam int NS = 16;
    localparam int NT = 8;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] trig_in = '0;
    logic [NS*4-1:0] slot_tsel;
    logic [NS*5-1:0] slot_chan;
    logic [NS*9-1:0] slot_acq;
    logic [4:0]    hp_cutoff = '0;
    logic          burst_en = 1'b0;
    logic [3:0]    burst_tsel = '0;
    logic [3:0]    burst_cnt = '0;
    logic [NI*4-1:0] int_sel;
    logic [NI-1:0] int_en = '0;
    logic [NI-1:0] int_clr = '0;
    logic [NS-1:0] ovf_clr = '0;
    logic          conv_done = 1'b0;
    logic          conv_start;
    logic [4:0]    conv_chan;
    logic [8:0]    conv_acq;
    logic          conv_busy;
    logic          result_valid;
    logic [3:0]    result_idx;
    logic [NI-1:0] int_flag;
    logic [NS-1:0] ovf_flag;
    logic [3:0]    rr_ptr;

    int tsel_a [NS];
    int chan_a [NS];
    int acq_a  [NS];
    int isel_a [NI];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int lat = 0;
    int glog [$];

    // model state
    logic [NS-1:0] m_pend, m_ovf;
    logic [NI-1:0] m_int;
    logic          m_busy, m_start, m_rv;
    int            m_cur, m_chan, m_acq, m_ridx, m_rr;

    always #2 clk = ~clk;

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            slot_tsel[s*4 +: 4] = 4'(tsel_a[s]);
            slot_chan[s*5 +: 5] = 5'(chan_a[s]);
            slot_acq[s*9 +: 9]  = 9'(acq_a[s]);
        end
        for (int i = 0; i < NI; i++) int_sel[i*4 +: 4] = 4'(isel_a[i]);
    end

    adc_soc_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .slot_tsel(slot_tsel),
        .slot_chan(slot_chan), .slot_acq(slot_acq), .hp_cutoff(hp_cutoff),
        .burst_en(burst_en), .burst_tsel(burst_tsel), .burst_cnt(burst_cnt),
        .int_sel(int_sel), .int_en(int_en), .int_clr(int_clr), .ovf_clr(ovf_clr),
        .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_acq(conv_acq), .conv_busy(conv_busy), .result_valid(result_valid),
        .result_idx(result_idx), .int_flag(int_flag), .ovf_flag(ovf_flag), .rr_ptr(rr_ptr)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit mfire(input int code, input logic [NT-1:0] ext, input logic [1:0] ie);
        if (code == 1) return ie[0];
        if (code == 2) return ie[1];
        if (code >= 3 && code < 3 + NT) return ext[code-3];
        return 1'b0;
    endfunction

    // Behavioural reference, advanced on each rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_ovf = '0; m_int = '0; m_busy = 0; m_start = 0; m_rv = 0;
            m_cur = 0; m_chan = 0; m_acq = 0; m_ridx = 0; m_rr = 15;
        end else begin
            bit done_now, ghp;
            logic [NI-1:0] ie;
            logic [NS-1:0] hitv, bm, gm;
            int g, cnt, cut;
            cut = int'(hp_cutoff);
            done_now = m_busy && conv_done;
            for (int i = 0; i < NI; i++) ie[i] = done_now && int_en[i] && (isel_a[i] == m_cur);
            bm = '0;
            if (burst_en && mfire(int'(burst_tsel), trig_in, ie[1:0])) begin
                cnt = 0;
                for (int k = 1; k <= NS; k++) begin
                    int idx;
                    idx = (m_rr + k) % NS;
                    if (idx >= cut && cnt <= int'(burst_cnt)) begin bm[idx] = 1'b1; cnt++; end
                end
            end
            for (int s = 0; s < NS; s++)
                hitv[s] = (s < cut || !burst_en) ? mfire(tsel_a[s], trig_in, ie[1:0]) : bm[s];
            g = -1; ghp = 0;
            if (!m_busy) begin
                for (int s = 0; s < cut && s < NS; s++) if (g < 0 && m_pend[s]) begin g = s; ghp = 1; end
                if (g < 0)
                    for (int k = 1; k <= NS; k++) begin
                        int idx;
                        idx = (m_rr + k) % NS;
                        if (g < 0 && idx >= cut && m_pend[idx]) g = idx;
                    end
            end
            gm = (g >= 0) ? (NS'(1) << g) : '0;
            m_ovf  = (m_ovf & ~ovf_clr) | (hitv & m_pend & ~gm);
            m_pend = (m_pend & ~gm) | hitv;
            m_int  = ie | (m_int & ~int_clr);
            m_rv = done_now;
            if (done_now) begin m_ridx = m_cur; m_busy = 0; end
            m_start = (g >= 0);
            if (g >= 0) begin
                m_cur = g; m_chan = chan_a[g]; m_acq = acq_a[g]; m_busy = 1;
                if (!ghp) m_rr = g;
            end
        end
    end

    // Compare every output each falling edge, log results and emulate a 3-cycle converter.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(conv_start == m_start, "R4", "conv_start", conv_start, m_start);
            chk(conv_busy == m_busy, "R3", "conv_busy", conv_busy, m_busy);
            chk(int'(conv_chan) == m_chan, "R4", "conv_chan", conv_chan, m_chan);
            chk(int'(conv_acq) == m_acq, "R4", "conv_acq", conv_acq, m_acq);
            chk(result_valid == m_rv, "R5", "result_valid", result_valid, m_rv);
            chk(int'(result_idx) == m_ridx, "R5", "result_idx", result_idx, m_ridx);
            chk(int'(rr_ptr) == m_rr, "R6", "rr_ptr", rr_ptr, m_rr);
            chk(int_flag == m_int, "R8", "int_flag", int_flag, m_int);
            chk(ovf_flag == m_ovf, "R2", "ovf_flag", ovf_flag, m_ovf);
            if (result_valid) glog.push_back(int'(result_idx));
        end
        conv_done = 1'b0;
        if (lat > 0) begin
            lat--;
            if (lat == 0) conv_done = 1'b1;
        end
        if (conv_start) lat = 3;
    end

    // Watchdog: a hung run still reaches the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            total++; bad++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic pulse(input int j);
        @(negedge clk) trig_in[j] = 1'b1;
        @(negedge clk) trig_in[j] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_log(input string tag, input int exp [$]);
        chk(glog.size() == exp.size(), tag, "grant count", glog.size(), exp.size());
        for (int i = 0; i < exp.size() && i < glog.size(); i++)
            chk(glog[i] == exp[i], tag, "grant order", glog[i], exp[i]);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin
            tsel_a[s] = 0;
            chan_a[s] = (s == 3) ? 5 : s + 3;
            acq_a[s]  = s * 5 + 2;
        end
        for (int i = 0; i < NI; i++) isel_a[i] = 0;
        idle(3);
        @(negedge clk);
        // R12: reset state
        chk(conv_start == 0 && conv_busy == 0 && result_valid == 0, "R12", "idle outputs", conv_busy, 0);
        chk(rr_ptr == 4'd15, "R6", "reset pointer", rr_ptr, 15);
        chk(int_flag == 0 && ovf_flag == 0, "R12", "flags clear", ovf_flag, 0);
        rst_n = 1'b1;
        idle(2);

        // R11 / R1: one pulse on line 0 (code 3) converts slots 0..3; slots 2 and 3 share channel 5
        for (int s = 0; s < 4; s++) tsel_a[s] = 3;
        tsel_a[4] = 15;          // R1: out-of-range code never fires
        glog.delete();
        pulse(0);
        pulse(7);
        idle(40);
        chk_log("R11", '{0, 1, 2, 3});
        chk(rr_ptr == 4'd3, "R6", "pointer after sequence", rr_ptr, 3);

        // R7: wheel slot 6 running, then slots 0,1 (high) and 7 (wheel) compete
        for (int s = 0; s < NS; s++) tsel_a[s] = 0;
        hp_cutoff = 5'd2;
        tsel_a[0] = 5; tsel_a[1] = 5; tsel_a[6] = 6; tsel_a[7] = 6;
        glog.delete();
        pulse(3);
        do @(negedge clk); while (!conv_start);
        pulse(2);
        idle(40);
        chk_log("R7", '{6, 0, 1, 7});
        chk(rr_ptr == 4'd7, "R7", "pointer resumed", rr_ptr, 7);

        // R2: second trigger while slot 13 still queued behind slot 12
        for (int s = 0; s < NS; s++) tsel_a[s] = 0;
        tsel_a[12] = 8; tsel_a[13] = 8;
        glog.delete();
        pulse(5);
        do @(negedge clk); while (!conv_start);
        pulse(5);
        chk(ovf_flag == 16'h2000, "R2", "overflow bit", ovf_flag, 16'h2000);
        idle(40);
        chk_log("R2", '{12, 13, 12});
        @(negedge clk) ovf_clr[13] = 1'b1;
        @(negedge clk) ovf_clr[13] = 1'b0;
        @(negedge clk);
        chk(ovf_flag == 0, "R2", "overflow cleared", ovf_flag, 0);

        // R9 / R8: ping-pong between {8,9} and {10,11} through flags 0 and 1
        for (int s = 0; s < NS; s++) tsel_a[s] = 0;
        isel_a[0] = 9; isel_a[1] = 11; int_en = 4'b0011;
        tsel_a[8] = 9; tsel_a[9] = 9; tsel_a[10] = 1; tsel_a[11] = 1;
        glog.delete();
        pulse(6);
        tsel_a[8] = 2; tsel_a[9] = 2;
        idle(60);
        chk(glog.size() >= 8, "R9", "retrigger count", glog.size(), 8);
        begin
            int exp8 [8] = '{8, 9, 10, 11, 8, 9, 10, 11};
            for (int i = 0; i < 8 && i < glog.size(); i++)
                chk(glog[i] == exp8[i], "R9", "ping-pong order", glog[i], exp8[i]);
        end
        chk(int_flag == 4'b0011, "R8", "flags set", int_flag, 3);
        for (int s = 0; s < NS; s++) tsel_a[s] = 0;
        idle(30);
        @(negedge clk) int_clr = 4'b0001;
        @(negedge clk) int_clr = 4'b0000;
        @(negedge clk);
        chk(int_flag == 4'b0010, "R8", "single clear", int_flag, 2);
        @(negedge clk) int_clr = 4'b0010;
        @(negedge clk) int_clr = 4'b0000;

        // R10: burst mode; wheel slot 5 ignores its own trigger, burst trigger queues three wheel slots
        hp_cutoff = 5'd4; burst_en = 1'b1; burst_tsel = 4'd10; burst_cnt = 4'd2;
        tsel_a[5] = 3;
        idle(2);
        glog.delete();
        pulse(0);
        idle(10);
        chk(glog.size() == 0, "R10", "own trigger ignored", glog.size(), 0);
        pulse(7);
        idle(40);
        chk(glog.size() == 3, "R10", "burst length", glog.size(), 3);
        for (int i = 0; i < glog.size(); i++)
            chk(glog[i] >= 4, "R10", "burst slot in wheel", glog[i], 4);
        if (glog.size() == 3) begin
            chk(glog[1] == (glog[0] + 1) % 16 || (glog[0] == 15 && glog[1] == 4), "R10", "consecutive", glog[1], glog[0] + 1);
        end

        idle(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule